// File: doc/BRIEF.md
# PCI Single-Phase Target Controller

This block is the bus-side engine of a 32-bit PCI target. It watches the shared bus for the start of a transaction. On the address edge it captures the address and the command and classifies the command. When the command is one it serves and the address belongs to it, it claims the cycle with medium decode timing. It then answers with one data phase, a retry, or a target abort. Single-cycle read and write strobes go to a local back end, which owns up to `NWIN` address windows, and to a configuration register file. Address matching is done outside: one match flag per window arrives on `win_hit` during the address phase.

Inputs and outputs of the shared lines are split: every driven line has a separate value and output enable, and a pad ring can combine them. Read data is fetched from the back end at the address edge, so it is ready when the target signals ready. The controller drives even parity one clock after each read data word. Two back-end inputs, `force_retry` and `force_abort`, replace normal completion for window hits.

The state machine has nine states:
- `ST_IDLE`: idle. On a falling frame it moves to `ST_ADDR` (address edge).
- `ST_ADDR`: decode wait. It moves to `ST_SKIP` when the cycle is not claimed, otherwise to `ST_CLAIM`.
- `ST_SKIP`: waits for frame and initiator ready both high, then returns to `ST_IDLE`.
- `ST_CLAIM`: drives select low. It moves to `ST_DATA`, `ST_RETRY` or `ST_ABORT` according to the latched response.
- `ST_DATA`: on initiator ready it moves to `ST_TURN` if frame is high, or to `ST_DISC` if frame is low.
- `ST_RETRY`, `ST_ABORT`, `ST_DISC`: each moves to `ST_TURN` once frame is high.
- `ST_TURN`: always returns to `ST_IDLE`.

Top module: `pci_tgt_ctrl`

## Requirements
- R1: The served command codes (C/BE# during the address phase) are 0010 I/O read, 0011 I/O write, 0110 memory read, 0111 memory write, 1010 configuration read and 1011 configuration write. Any other code is never claimed: `devsel_n` stays high, `ctl_oe` stays low and no strobe is issued. A memory or I/O command with no window hit is not claimed either. When several hit bits are set, the lowest-numbered window is used.
- R2: Codes 1100 and 1110 act exactly as memory read. Code 1111 acts exactly as memory write.
- R3: `loc_addr` shows the AD value captured on the address edge. It holds that value through the transaction, whatever AD carries afterwards.
- R4: A configuration command is claimed only when `idsel` is 1, AD[1:0] is 00 and AD[10:8] is 000 on the address edge. `cfg_index` is AD[7:2]. The force inputs do not affect configuration cycles.
- R5: `devsel_n` first goes low in the clock that follows the first clock after the address edge (medium timing), not earlier.
- R6: While `force_retry` is high, a window hit is answered with `stop_n` low, `trdy_n` high and `devsel_n` low. No strobe of any kind is issued.
- R7: While `force_abort` is high, a window hit is claimed first and then answered with `devsel_n` high and `stop_n` low. `abort_flag` pulses for exactly that first abort clock, and no strobe is issued.
- R8: When both force inputs are high, the abort response is given.
- R9: During read data phases `ad_oe` is 1. One clock after each driven word, `par_oe` is 1 and `par_out` is the XOR of that word and the C/BE# lines of the same clock.
- R10: Only one data phase is transferred per transaction. If frame is low when ready is first given, `stop_n` is low together with `trdy_n`. After the transfer `trdy_n` goes high while `stop_n` stays low until frame is high.
- R11: A data phase completes on a clock edge where `irdy_n` and `trdy_n` are both low. A write then pulses the selected `loc_wr` bit (or `cfg_wr`) for one clock, with the AD data on `loc_wdata` and the inverted C/BE# lines on `loc_be`. A read pulses the selected `loc_rd` bit (or `cfg_rd`) for one clock right after the address edge. At most one strobe is high at a time.
- R12: After reset, and when the controller is idle, `ctl_oe` is 0. At the end of every claimed cycle, `trdy_n`, `stop_n` and `devsel_n` are driven high for one clock, and after that clock `ctl_oe` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_in | input | 32 | Address/data bus as seen by the target |
| cbe_n | input | 4 | Command (address phase) or active-low byte enables |
| frame_n | input | 1 | Initiator cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select |
| win_hit | input | NWIN | Per-window address match, valid in the address phase |
| force_retry | input | 1 | Answer window hits with retry |
| force_abort | input | 1 | Answer window hits with target abort |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Output enable for `ad_out` |
| par_out | output | 1 | Even parity for the previous read word |
| par_oe | output | 1 | Output enable for `par_out` |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop, active low |
| devsel_n | output | 1 | Device select, active low |
| ctl_oe | output | 1 | Output enable for trdy_n, stop_n, devsel_n |
| loc_addr | output | 32 | Latched transaction address |
| loc_wr | output | NWIN | One-clock write strobe per window |
| loc_rd | output | NWIN | One-clock read strobe per window |
| loc_wdata | output | 32 | Write data captured at completion |
| loc_be | output | 4 | Active-high byte enables of the write |
| loc_rdata | input | 32*NWIN | Read data per window, valid the clock after `loc_rd` |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_rd | output | 1 | Configuration read strobe |
| cfg_index | output | 6 | Configuration dword index |
| cfg_rdata | input | 32 | Configuration read data |
| abort_flag | output | 1 | Pulse when a target abort is signaled |

## Verification
Each scenario runs a full initiator sequence and sweeps the command code. The sweep covers the six served codes, the three aliases and several unserved codes, so wrong classification shows up as a missing claim or a wrong strobe. A window-hit pattern with several bits set checks the window priority. Configuration addresses with a wrong select, a type-1 marker or a nonzero function number check the configuration filter. Runs with `force_retry`, `force_abort` or both set separate the three stop shapes and confirm that no strobe escapes. A run that holds frame low through the data phase exercises the disconnect path and checks that only one word is transferred.

// File: rtl/pci_tgt_pkg.sv
`timescale 1ns/1ps
package pci_tgt_pkg;
    localparam int AD_W = 32;
    localparam int BE_W = 4;
    localparam int CFG_IDX_W = 6;

    typedef enum logic [1:0] {
        CC_NONE,
        CC_MEM,
        CC_IO,
        CC_CFG
    } cmd_class_e;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_NORM,
        RK_RETRY,
        RK_ABORT
    } rsp_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SKIP,
        ST_CLAIM,
        ST_DATA,
        ST_RETRY,
        ST_ABORT,
        ST_DISC,
        ST_TURN
    } tgt_state_e;
endpackage

// File: rtl/pci_tgt_cmd_dec.sv
`timescale 1ns/1ps
module pci_tgt_cmd_dec
    import pci_tgt_pkg::*;
(
    input  logic [BE_W-1:0] cmd,
    output cmd_class_e      cls,
    output logic            is_wr
);
    always_comb begin
        cls   = CC_NONE;
        is_wr = 1'b0;
        unique case (cmd)
            4'b0010: cls = CC_IO;
            4'b0011: begin cls = CC_IO;  is_wr = 1'b1; end
            4'b0110: cls = CC_MEM;
            4'b0111: begin cls = CC_MEM; is_wr = 1'b1; end
            4'b1010: cls = CC_CFG;
            4'b1011: begin cls = CC_CFG; is_wr = 1'b1; end
            4'b1100: cls = CC_MEM;                      // read multiple alias
            4'b1110: cls = CC_MEM;                      // read line alias
            4'b1111: begin cls = CC_MEM; is_wr = 1'b1; end // write+invalidate alias
            default: begin cls = CC_NONE; is_wr = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pci_tgt_parity.sv
`timescale 1ns/1ps
module pci_tgt_parity
    import pci_tgt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] data,
    input  logic [BE_W-1:0] be_n,
    input  logic            drive,
    output logic            par_out,
    output logic            par_oe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= ^{data, be_n};
            par_oe  <= drive;
        end
    end

    // R9
    par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> $past(drive));
endmodule

// File: rtl/pci_tgt_fsm.sv
`timescale 1ns/1ps
module pci_tgt_fsm
    import pci_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic       irdy_n,
    input  cmd_class_e cls,
    input  logic       cmd_wr,
    input  logic       cfg_ok,
    input  logic       hit_any,
    input  logic       force_retry,
    input  logic       force_abort,
    output logic       trdy_n,
    output logic       stop_n,
    output logic       devsel_n,
    output logic       ctl_oe,
    output logic       ad_oe,
    output logic       abort_flag,
    output logic       addr_edge,
    output logic       rd_issue,
    output logic       xfer_now,
    output logic       rd_load,
    output logic       wr_q,
    output logic       cfg_q
);
    tgt_state_e state, nxt;
    rsp_kind_e  rsp_c, rsp_q;

    always_comb begin
        rsp_c = RK_NONE;
        if (cls == CC_CFG)
            rsp_c = cfg_ok ? RK_NORM : RK_NONE;
        else if (cls != CC_NONE && hit_any)
            rsp_c = force_abort ? RK_ABORT : (force_retry ? RK_RETRY : RK_NORM);
    end

    assign addr_edge = (state == ST_IDLE) && !frame_n;
    assign rd_issue  = addr_edge && (rsp_c == RK_NORM) && !cmd_wr;
    assign xfer_now  = (state == ST_DATA) && !irdy_n;
    assign rd_load   = (state == ST_CLAIM) && (rsp_q == RK_NORM) && !wr_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!frame_n) nxt = ST_ADDR;
            ST_ADDR:  nxt = (rsp_q == RK_NONE) ? ST_SKIP : ST_CLAIM;
            ST_SKIP:  if (frame_n && irdy_n) nxt = ST_IDLE;
            ST_CLAIM: nxt = (rsp_q == RK_ABORT) ? ST_ABORT :
                            ((rsp_q == RK_RETRY) ? ST_RETRY : ST_DATA);
            ST_DATA:  if (!irdy_n) nxt = frame_n ? ST_TURN : ST_DISC;
            ST_RETRY, ST_ABORT, ST_DISC: if (frame_n) nxt = ST_TURN;
            ST_TURN:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register and transaction latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rsp_q <= RK_NONE;
            wr_q  <= 1'b0;
            cfg_q <= 1'b0;
        end else begin
            state <= nxt;
            if (addr_edge) begin
                rsp_q <= rsp_c;
                wr_q  <= cmd_wr;
                cfg_q <= (cls == CC_CFG);
            end
        end
    end

    // registered bus outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trdy_n     <= 1'b1;
            stop_n     <= 1'b1;
            devsel_n   <= 1'b1;
            ctl_oe     <= 1'b0;
            ad_oe      <= 1'b0;
            abort_flag <= 1'b0;
        end else begin
            devsel_n   <= !(nxt inside {ST_CLAIM, ST_DATA, ST_RETRY, ST_DISC});
            trdy_n     <= !(nxt == ST_DATA);
            stop_n     <= !((nxt inside {ST_RETRY, ST_ABORT, ST_DISC}) ||
                            (nxt == ST_DATA && !frame_n));
            ctl_oe     <= !(nxt inside {ST_IDLE, ST_ADDR, ST_SKIP});
            ad_oe      <= (nxt == ST_DATA) && !wr_q;
            abort_flag <= (nxt == ST_ABORT) && (state != ST_ABORT);
        end
    end

    // R5
    medium_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> $past(!frame_n, 2));
    // R10
    single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n) |=> trdy_n);
    // R12
    turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_oe) |-> $past(trdy_n && stop_n && devsel_n));
    // R7
    abort_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_flag |=> !stop_n || $past(frame_n));
endmodule

// File: rtl/pci_tgt_ctrl.sv
`timescale 1ns/1ps
module pci_tgt_ctrl
    import pci_tgt_pkg::*;
#(
    parameter int NWIN = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AD_W-1:0]      ad_in,
    input  logic [BE_W-1:0]      cbe_n,
    input  logic                 frame_n,
    input  logic                 irdy_n,
    input  logic                 idsel,
    input  logic [NWIN-1:0]      win_hit,
    input  logic                 force_retry,
    input  logic                 force_abort,
    output logic [AD_W-1:0]      ad_out,
    output logic                 ad_oe,
    output logic                 par_out,
    output logic                 par_oe,
    output logic                 trdy_n,
    output logic                 stop_n,
    output logic                 devsel_n,
    output logic                 ctl_oe,
    output logic [AD_W-1:0]      loc_addr,
    output logic [NWIN-1:0]      loc_wr,
    output logic [NWIN-1:0]      loc_rd,
    output logic [AD_W-1:0]      loc_wdata,
    output logic [BE_W-1:0]      loc_be,
    input  logic [NWIN*AD_W-1:0] loc_rdata,
    output logic                 cfg_wr,
    output logic                 cfg_rd,
    output logic [CFG_IDX_W-1:0] cfg_index,
    input  logic [AD_W-1:0]      cfg_rdata,
    output logic                 abort_flag
);
    localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1;

    cmd_class_e      cls;
    logic            cmd_wr, cfg_ok, hit_any;
    logic            addr_edge, rd_issue, xfer_now, rd_load, wr_q, cfg_q;
    logic [IDXW-1:0] idx_c, idx_q;
    logic [AD_W-1:0] addr_q;
    logic [AD_W-1:0] rd_bank [NWIN];

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_bank
            assign rd_bank[g] = loc_rdata[g*AD_W +: AD_W];
        end
    endgenerate

    always_comb begin
        idx_c = '0;
        for (int i = NWIN - 1; i >= 0; i--)
            if (win_hit[i]) idx_c = IDXW'(i);
    end

    assign hit_any   = |win_hit;
    assign cfg_ok    = idsel && (ad_in[1:0] == 2'b00) && (ad_in[10:8] == 3'b000);
    assign loc_addr  = addr_q;
    assign cfg_index = addr_q[7:2];

    pci_tgt_cmd_dec i_dec (
        .cmd   (cbe_n),
        .cls   (cls),
        .is_wr (cmd_wr)
    );

    pci_tgt_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_n     (frame_n),
        .irdy_n      (irdy_n),
        .cls         (cls),
        .cmd_wr      (cmd_wr),
        .cfg_ok      (cfg_ok),
        .hit_any     (hit_any),
        .force_retry (force_retry),
        .force_abort (force_abort),
        .trdy_n      (trdy_n),
        .stop_n      (stop_n),
        .devsel_n    (devsel_n),
        .ctl_oe      (ctl_oe),
        .ad_oe       (ad_oe),
        .abort_flag  (abort_flag),
        .addr_edge   (addr_edge),
        .rd_issue    (rd_issue),
        .xfer_now    (xfer_now),
        .rd_load     (rd_load),
        .wr_q        (wr_q),
        .cfg_q       (cfg_q)
    );

    pci_tgt_parity i_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .data    (ad_out),
        .be_n    (cbe_n),
        .drive   (ad_oe),
        .par_out (par_out),
        .par_oe  (par_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            idx_q     <= '0;
            ad_out    <= '0;
            loc_wr    <= '0;
            loc_rd    <= '0;
            cfg_wr    <= 1'b0;
            cfg_rd    <= 1'b0;
            loc_wdata <= '0;
            loc_be    <= '0;
        end else begin
            loc_wr <= '0;
            loc_rd <= '0;
            cfg_wr <= 1'b0;
            cfg_rd <= 1'b0;
            if (addr_edge) begin
                addr_q <= ad_in;
                idx_q  <= idx_c;
            end
            if (rd_issue) begin
                if (cls == CC_CFG) cfg_rd <= 1'b1;
                else               loc_rd <= NWIN'(1) << idx_c;
            end
            if (rd_load)
                ad_out <= cfg_q ? cfg_rdata : rd_bank[idx_q];
            if (xfer_now && wr_q) begin
                if (cfg_q) cfg_wr <= 1'b1;
                else       loc_wr <= NWIN'(1) << idx_q;
                loc_wdata <= ad_in;
                loc_be    <= ~cbe_n;
            end
        end
    end

    // R11
    strobe_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|loc_wr || cfg_wr) |-> $past(!irdy_n && !trdy_n));
    // R11
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loc_wr, loc_rd, cfg_wr, cfg_rd}));
    // R6
    retry_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && trdy_n && !devsel_n && !$past(!trdy_n)) |=> (loc_wr == '0) && !cfg_wr);
endmodule

// File: tb/test_pci_tgt_ctrl.sv
`timescale 1ns/1ps
module test_pci_tgt_ctrl;
    localparam int NWIN = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
    logic [NWIN-1:0] win_hit = '0;
    logic f_retry = 1'b0, f_abort = 1'b0;
    logic [31:0] ad_out, loc_addr, loc_wdata, cfg_rdata;
    logic ad_oe, par_out, par_oe, trdy_n, stop_n, devsel_n, ctl_oe;
    logic [NWIN-1:0] loc_wr, loc_rd;
    logic [3:0] loc_be;
    logic [NWIN*32-1:0] loc_rdata;
    logic cfg_wr, cfg_rd, abort_flag;
    logic [5:0] cfg_index;

    int total = 0;
    int bad = 0;

    logic s_dev[6], s_trdy[6], s_stop[6], s_oe[6], s_adoe[6], s_paroe[6], s_par[6], s_flag[6];
    logic s_cwr[6], s_crd[6];
    logic [31:0] s_adout[6], s_addr[6], s_wd[6];
    logic [3:0] s_be[6];
    logic [5:0] s_lwr[6], s_lrd[6], s_cidx[6];

    always #2 clk = ~clk;

    pci_tgt_ctrl #(.NWIN(NWIN)) i_pci_tgt_ctrl (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n(cbe_n), .frame_n(frame_n),
        .irdy_n(irdy_n), .idsel(idsel), .win_hit(win_hit), .force_retry(f_retry),
        .force_abort(f_abort), .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out),
        .par_oe(par_oe), .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n),
        .ctl_oe(ctl_oe), .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_rd(loc_rd),
        .loc_wdata(loc_wdata), .loc_be(loc_be), .loc_rdata(loc_rdata),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_index(cfg_index),
        .cfg_rdata(cfg_rdata), .abort_flag(abort_flag)
    );

    function automatic logic [31:0] win_data(input int w);
        return 32'h1357_9BD0 + 32'(w) * 32'h0102_0304;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic snap(input int k);
        s_dev[k] = devsel_n;  s_trdy[k] = trdy_n;   s_stop[k] = stop_n;
        s_oe[k] = ctl_oe;     s_adoe[k] = ad_oe;    s_paroe[k] = par_oe;
        s_par[k] = par_out;   s_flag[k] = abort_flag;
        s_cwr[k] = cfg_wr;    s_crd[k] = cfg_rd;    s_adout[k] = ad_out;
        s_addr[k] = loc_addr; s_wd[k] = loc_wdata;  s_be[k] = loc_be;
        s_lwr[k] = loc_wr;    s_lrd[k] = loc_rd;    s_cidx[k] = cfg_index;
    endtask

    function automatic int strobes();
        int n = 0;
        for (int k = 0; k < 6; k++)
            n += $countones(s_lwr[k]) + $countones(s_lrd[k]) + int'(s_cwr[k]) + int'(s_crd[k]);
        return n;
    endfunction

    task automatic run(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                       input logic [5:0] hit, input logic [31:0] wd, input logic [3:0] be,
                       input logic single);
        @(posedge clk); #1;
        frame_n = 1'b0; ad_in = addr; cbe_n = cmd; idsel = sel; win_hit = hit;
        @(posedge clk); #1;
        frame_n = single; irdy_n = 1'b0; ad_in = wd; cbe_n = ~be; idsel = 1'b0; win_hit = '0;
        @(negedge clk); snap(0);
        @(posedge clk); @(negedge clk); snap(1);
        @(posedge clk); @(negedge clk); snap(2);
        @(posedge clk); #1;
        if (single) irdy_n = 1'b1; else frame_n = 1'b1;
        ad_in = 32'hFFFF_0000;
        @(negedge clk); snap(3);
        @(posedge clk); #1; irdy_n = 1'b1; frame_n = 1'b1; cbe_n = 4'hF;
        @(negedge clk); snap(4);
        @(posedge clk); @(negedge clk); snap(5);
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R12 reset ctl_oe", 32'(ctl_oe), 0);
        chk("R12 reset devsel_n", 32'(devsel_n), 1);
        chk("R12 reset trdy_n", 32'(trdy_n), 1);
        chk("R12 reset stop_n", 32'(stop_n), 1);
        chk("R9 reset ad_oe", 32'(ad_oe), 0);
        chk("R9 reset par_oe", 32'(par_oe), 0);
    endtask

    task automatic t_mem_read();
        logic [31:0] exp_d = win_data(2);
        logic [3:0] be = 4'b0101;
        run(4'b0110, 32'h0000_1208, 1'b0, 6'b000100, 32'h0, be, 1'b1);
        chk("R5 devsel not fast", 32'(s_dev[0]), 1);
        chk("R5 devsel medium", 32'(s_dev[1]), 0);
        chk("R11 read strobe", 32'(s_lrd[0]), 32'b000100);
        chk("R11 read strobe one clock", 32'(s_lrd[1]), 0);
        chk("R11 trdy wait", 32'(s_trdy[1]), 1);
        chk("R11 trdy given", 32'(s_trdy[2]), 0);
        chk("R10 no stop single", 32'(s_stop[2]), 1);
        chk("R9 read data", s_adout[2], exp_d);
        chk("R9 ad_oe", 32'(s_adoe[2]), 1);
        chk("R9 par_oe", 32'(s_paroe[3]), 1);
        chk("R9 parity", 32'(s_par[3]), 32'(^{exp_d, ~be}));
        chk("R12 turn devsel", 32'(s_dev[3]), 1);
        chk("R12 turn trdy", 32'(s_trdy[3]), 1);
        chk("R12 turn stop", 32'(s_stop[3]), 1);
        chk("R12 turn driven", 32'(s_oe[3]), 1);
        chk("R12 released", 32'(s_oe[4]), 0);
        chk("R9 par released", 32'(s_paroe[4]), 0);
        chk("R3 address held", s_addr[3], 32'h0000_1208);
    endtask

    task automatic t_mem_write();
        run(4'b0111, 32'h0000_4000, 1'b0, 6'b000001, 32'hDEAD_BEEF, 4'b0110, 1'b1);
        chk("R11 no strobe before xfer", 32'(s_lwr[2]), 0);
        chk("R11 write strobe", 32'(s_lwr[3]), 32'b000001);
        chk("R11 write strobe one clock", 32'(s_lwr[4]), 0);
        chk("R11 write data", s_wd[3], 32'hDEAD_BEEF);
        chk("R11 write be", 32'(s_be[3]), 32'b0110);
        chk("R11 no read strobe", 32'(s_lrd[0]), 0);
        chk("R9 no drive on write", 32'(s_adoe[2]), 0);
        chk("R3 address held", s_addr[4], 32'h0000_4000);
    endtask

    task automatic t_alias();
        run(4'b1100, 32'h10, 1'b0, 6'b000010, 32'h0, 4'hF, 1'b1);
        chk("R2 read multiple", 32'(s_lrd[0]), 32'b000010);
        chk("R2 read multiple data", s_adout[2], win_data(1));
        run(4'b1110, 32'h20, 1'b0, 6'b001000, 32'h0, 4'hF, 1'b1);
        chk("R2 read line", 32'(s_lrd[0]), 32'b001000);
        run(4'b1111, 32'h30, 1'b0, 6'b010000, 32'h0BAD_F00D, 4'hF, 1'b1);
        chk("R2 write invalidate", 32'(s_lwr[3]), 32'b010000);
        chk("R2 write invalidate data", s_wd[3], 32'h0BAD_F00D);
    endtask

    task automatic t_io();
        run(4'b0010, 32'h0000_0044, 1'b0, 6'b100000, 32'h0, 4'hF, 1'b1);
        chk("R1 io read", 32'(s_lrd[0]), 32'b100000);
        chk("R1 io read data", s_adout[2], win_data(5));
        run(4'b0011, 32'h0000_0048, 1'b0, 6'b101000, 32'h0000_00A5, 4'b0001, 1'b1);
        chk("R1 io write lowest window", 32'(s_lwr[3]), 32'b001000);
        chk("R1 io write be", 32'(s_be[3]), 32'b0001);
    endtask

    task automatic t_ignored();
        logic [3:0] codes [4] = '{4'b0000, 4'b0001, 4'b0100, 4'b1000};
        for (int c = 0; c < 4; c++) begin
            run(codes[c], 32'h100, 1'b1, 6'b111111, 32'h0, 4'hF, 1'b1);
            chk("R1 unserved no devsel", 32'(s_dev[1] & s_dev[2]), 1);
            chk("R1 unserved no drive", 32'(s_oe[2]), 0);
            chk("R1 unserved no strobe", 32'(strobes()), 0);
        end
        run(4'b0110, 32'h100, 1'b0, 6'b000000, 32'h0, 4'hF, 1'b1);
        chk("R1 miss no devsel", 32'(s_dev[2]), 1);
        chk("R1 miss no strobe", 32'(strobes()), 0);
    endtask

    task automatic t_cfg();
        run(4'b1011, 32'h0000_0034, 1'b1, 6'b000000, 32'h5555_AAAA, 4'b1111, 1'b1);
        chk("R4 cfg write claimed", 32'(s_dev[1]), 0);
        chk("R4 cfg write strobe", 32'(s_cwr[3]), 1);
        chk("R4 cfg index", 32'(s_cidx[3]), 32'h0D);
        chk("R4 cfg write data", s_wd[3], 32'h5555_AAAA);
        chk("R4 cfg no window strobe", 32'(s_lwr[3]), 0);
        run(4'b1010, 32'h0000_0010, 1'b1, 6'b000000, 32'h0, 4'hF, 1'b1);
        chk("R4 cfg read strobe", 32'(s_crd[0]), 1);
        chk("R4 cfg read data", s_adout[2], 32'hC0FF_EE01);
        chk("R4 cfg read index", 32'(s_cidx[2]), 32'h04);
        run(4'b1010, 32'h0000_0010, 1'b0, 6'b000000, 32'h0, 4'hF, 1'b1);
        chk("R4 no idsel", 32'(s_dev[1] & s_dev[2]), 1);
        run(4'b1010, 32'h0000_0011, 1'b1, 6'b000000, 32'h0, 4'hF, 1'b1);
        chk("R4 type 1 refused", 32'(s_dev[1] & s_dev[2]), 1);
        run(4'b1011, 32'h0000_0110, 1'b1, 6'b000000, 32'h0, 4'hF, 1'b1);
        chk("R4 function 1 refused", 32'(strobes()), 0);
        f_retry = 1'b1; f_abort = 1'b1;
        run(4'b1010, 32'h0000_0008, 1'b1, 6'b000000, 32'h0, 4'hF, 1'b1);
        f_retry = 1'b0; f_abort = 1'b0;
        chk("R4 force ignored on cfg", 32'(s_trdy[2]), 0);
        chk("R4 force ignored no abort", 32'(s_flag[2]), 0);
    endtask

    task automatic t_retry();
        f_retry = 1'b1;
        run(4'b0110, 32'h200, 1'b0, 6'b000001, 32'h0, 4'hF, 1'b1);
        chk("R6 retry stop", 32'(s_stop[2]), 0);
        chk("R6 retry trdy", 32'(s_trdy[2]), 1);
        chk("R6 retry devsel", 32'(s_dev[2]), 0);
        chk("R6 retry no strobe", 32'(strobes()), 0);
        chk("R12 retry turn", 32'(s_stop[3] & s_oe[3]), 1);
        chk("R12 retry released", 32'(s_oe[4]), 0);
        run(4'b0111, 32'h204, 1'b0, 6'b000001, 32'h1, 4'hF, 1'b1);
        chk("R6 retry write no strobe", 32'(strobes()), 0);
        f_retry = 1'b0;
    endtask

    task automatic t_abort();
        f_abort = 1'b1;
        run(4'b0111, 32'h300, 1'b0, 6'b000100, 32'h77, 4'hF, 1'b1);
        chk("R7 claimed first", 32'(s_dev[1]), 0);
        chk("R7 abort devsel", 32'(s_dev[2]), 1);
        chk("R7 abort stop", 32'(s_stop[2]), 0);
        chk("R7 abort trdy", 32'(s_trdy[2]), 1);
        chk("R7 abort flag", 32'(s_flag[2]), 1);
        chk("R7 abort flag pulse", 32'(s_flag[3]), 0);
        chk("R7 abort no strobe", 32'(strobes()), 0);
        f_retry = 1'b1;
        run(4'b0110, 32'h304, 1'b0, 6'b000100, 32'h0, 4'hF, 1'b1);
        chk("R8 abort wins devsel", 32'(s_dev[2]), 1);
        chk("R8 abort wins flag", 32'(s_flag[2]), 1);
        chk("R8 abort wins no strobe", 32'(strobes()), 0);
        f_retry = 1'b0; f_abort = 1'b0;
    endtask

    task automatic t_burst();
        run(4'b0111, 32'h400, 1'b0, 6'b000010, 32'hCAFE_0001, 4'hF, 1'b0);
        chk("R10 stop with trdy", 32'(s_stop[2]), 0);
        chk("R10 trdy with stop", 32'(s_trdy[2]), 0);
        chk("R10 one write", 32'(s_lwr[3]), 32'b000010);
        chk("R10 trdy off after", 32'(s_trdy[3]), 1);
        chk("R10 stop held", 32'(s_stop[3]), 0);
        chk("R10 devsel held", 32'(s_dev[3]), 0);
        chk("R10 no second write", 32'(strobes()), 1);
        chk("R12 burst turn", 32'(s_stop[4] & s_dev[4] & s_trdy[4] & s_oe[4]), 1);
        chk("R12 burst released", 32'(s_oe[5]), 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        for (int w = 0; w < NWIN; w++) loc_rdata[w*32 +: 32] = win_data(w);
        cfg_rdata = 32'hC0FF_EE01;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem_read();
        t_mem_write();
        t_alias();
        t_io();
        t_ignored();
        t_cfg();
        t_retry();
        t_abort();
        t_burst();
        finish_run();
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end
endmodule